// File: doc/BRIEF.md
# Divided Countdown Interrupt Timer

This block is a per-core countdown timer. Software programs a divide setting, an interrupt entry (vector number, mask bit, periodic or one-shot mode) and an initial count through a small register port. Writing the initial count copies it into the current count and starts the countdown, which advances once per pulse of a prescaler driven by the core clock. When the count runs out, the block raises a one-cycle request carrying the programmed vector toward the interrupt priority logic, provided the entry is unmasked.

In periodic mode the count is reloaded on expiry, less whatever part of the last decrement went past zero, so the average period stays exact when the step size does not divide the count. An initial count of zero stops the timer. A global enable bit in the control register guards the entry: while the enable is clear, every write to the entry comes out masked.

Top module: `cdtimer`

Register map (addr): 0 control (bit 0 = enable), 1 entry (bits VW-1:0 vector, bit 16 mask, bit 17 periodic), 2 initial count, 3 current count, 4 divide. Other addresses read as zero and ignore writes.

## Requirements
- R1: The divide register keeps only bits 3, 1 and 0 (other bits read back 0); with code {bit3,bit1,bit0} = c, the prescaler ratio is 2^((c+1) mod 8), giving 2, 4, 8, 16, 32, 64, 128 for codes 0..6 and 1 for code 7.
- R2: A write to the initial count loads the current count with the written value in the same edge and clears the prescaler, so the first decrement lands exactly one prescaler ratio of cycles after the write edge.
- R3: Each prescaler pulse lowers the current count by STEP while the count exceeds STEP; a pulse that finds the count at or below STEP is an expiry.
- R4: While the initial count is zero the timer does not count and no request is raised.
- R5: In one-shot mode an expiry leaves the current count at 0, and it stays 0 with no further requests until the initial count is written again.
- R6: In periodic mode an expiry reloads the current count with the initial count minus the overshoot (STEP minus the count at expiry), or with 0 when the overshoot is not smaller than the initial count; the current count never exceeds the initial count.
- R7: An expiry drives irq_req high for the cycle after its edge with irq_vec equal to the entry vector, only if the entry mask bit (bit 16) is clear; a masked expiry raises nothing but still updates the count.
- R8: While control bit 0 is clear, a write to the entry stores the mask bit as 1 whatever was written.
- R9: After reset the entry reads 0x0001_0000 (masked), the counts, divide and control read 0, and irq_req is low.
- R10: The current count is read-only: a write to address 3 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also the prescaler source |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq_req | output | 1 | One-cycle interrupt request on unmasked expiry |
| irq_vec | output | VW | Vector accompanying irq_req |

## Verification
The bench builds the timer with STEP = 3 and CW = 16 instead of the default step of one. A step of three makes the overshoot nonzero at most expiries, so periodic reloads of initial-minus-overshoot and the clamp to zero when the overshoot reaches the initial count both occur within a few dozen cycles. Divide codes 7, 0, 2 and 5 are used so that ratios 1, 2, 8 and 64 are timed to the exact edge.

// File: rtl/cdtimer.sv
module cdtimer #(
  parameter int CW   = 32,
  parameter int STEP = 1,
  parameter int VW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq_req,
  output logic [VW-1:0] irq_vec
);

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_ENTRY = 3'd1;
  localparam logic [2:0] A_INIT  = 3'd2;
  localparam logic [2:0] A_CUR   = 3'd3;
  localparam logic [2:0] A_DIV   = 3'd4;
  localparam int         MASK_B  = 16;
  localparam int         PER_B   = 17;
  localparam logic [CW-1:0] STEP_C = CW'(STEP);

  logic          sw_en_q;
  logic [VW-1:0] vec_q;
  logic          mask_q;
  logic          per_q;
  logic [CW-1:0] init_q;
  logic [CW-1:0] cur_q;
  logic [3:0]    div_q;
  logic [6:0]    pcnt_q;

  wire wr_ctrl  = wr_en && (addr == A_CTRL);
  wire wr_entry = wr_en && (addr == A_ENTRY);
  wire wr_init  = wr_en && (addr == A_INIT);
  wire wr_div   = wr_en && (addr == A_DIV);
  wire unused_wdata = ^wdata;

  wire [2:0] div_code = {div_q[3], div_q[1:0]};
  wire [2:0] div_sh   = div_code + 3'd1;
  wire [7:0] div_lim  = (8'd1 << div_sh) - 8'd1;
  wire       tick     = {1'b0, pcnt_q} >= div_lim;

  wire          running = (init_q != '0) && (per_q || (cur_q != '0));
  wire          at_end  = cur_q <= STEP_C;
  wire          expire  = tick && running && !wr_init && at_end;
  wire [CW-1:0] ovr     = STEP_C - cur_q;
  wire [CW-1:0] reload  = (ovr < init_q) ? (init_q - ovr) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en_q <= 1'b0;
      vec_q   <= '0;
      mask_q  <= 1'b1;
      per_q   <= 1'b0;
      div_q   <= '0;
    end else begin
      if (wr_ctrl) sw_en_q <= wdata[0];
      if (wr_entry) begin
        vec_q  <= wdata[VW-1:0];
        mask_q <= wdata[MASK_B] | ~sw_en_q;
        per_q  <= wdata[PER_B];
      end
      if (wr_div) div_q <= wdata[3:0] & 4'hB;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      init_q <= '0;
      cur_q  <= '0;
    end else begin
      if (wr_init || tick) pcnt_q <= '0;
      else                 pcnt_q <= pcnt_q + 7'd1;
      if (wr_init) begin
        init_q <= wdata[CW-1:0];
        cur_q  <= wdata[CW-1:0];
      end else if (tick && running) begin
        if (at_end) cur_q <= per_q ? reload : '0;
        else        cur_q <= cur_q - STEP_C;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else begin
      irq_req <= expire && !mask_q;
      if (expire && !mask_q) irq_vec <= vec_q;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[0] = sw_en_q;
      A_ENTRY: begin
        rdata[VW-1:0]  = vec_q;
        rdata[MASK_B]  = mask_q;
        rdata[PER_B]   = per_q;
      end
      A_INIT:  rdata = 32'(init_q);
      A_CUR:   rdata = 32'(cur_q);
      A_DIV:   rdata[3:0] = div_q;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/cdtimer_chk.sv
module cdtimer_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    addr,
  input logic          sw_en,
  input logic          mask,
  input logic          per,
  input logic [CW-1:0] init,
  input logic [CW-1:0] cur,
  input logic          irq_req
);

  assert_reset_masked_R9: assert property (@(posedge clk)
    !rst_n |=> (mask && !irq_req && cur == '0));

  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !$past(mask));

  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (init == '0) |=> !irq_req);

  assert_oneshot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!per && cur == '0 && !(wr_en && addr == 3'd2)) |=> (cur == '0));

  assert_force_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && !sw_en) |=> mask);

  assert_cur_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cur <= init);

endmodule

bind cdtimer cdtimer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .sw_en(sw_en_q), .mask(mask_q), .per(per_q),
  .init(init_q), .cur(cur_q), .irq_req(irq_req)
);

// File: tb/sim_cdtimer.sv
`timescale 1ns/1ps
module sim_cdtimer;
  localparam int CW = 16;
  localparam int STEP = 3;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq_req;
  logic [VW-1:0] irq_vec;

  int cyc = 0;
  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  int exp_cyc[$];
  int exp_vec[$];

  cdtimer #(.CW(CW), .STEP(STEP), .VW(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic push(input int c, input int v);
    exp_cyc.push_back(c);
    exp_vec.push_back(v);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && irq_req) begin
      nchk++;
      if (exp_cyc.size() == 0) begin
        nerr++;
        $display("FAIL R7 unexpected request: actual cycle %0d vec %h expected none", cyc, irq_vec);
      end else begin
        int ec, ev;
        ec = exp_cyc.pop_front();
        ev = exp_vec.pop_front();
        if (ec != cyc || int'(irq_vec) != ev) begin
          nerr++;
          $display("FAIL R7 request: actual cycle %0d vec %h expected cycle %0d vec %h",
                   cyc, irq_vec, ec, ev);
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(3'd1, d); chk("R9 entry masked", d, 32'h0001_0000);
    rd(3'd3, d); chk("R9 cur zero", d, 0);
    rd(3'd4, d); chk("R9 div zero", d, 0);
    rd(3'd0, d); chk("R9 ctrl zero", d, 0);
    chk("R9 irq low", {31'd0, irq_req}, 0);

    wr(3'd1, 32'h0000_0041);
    rd(3'd1, d); chk("R8 forced mask", d, 32'h0001_0041);
    wr(3'd0, 32'h1);
    wr(3'd1, 32'h0000_0041);
    rd(3'd1, d); chk("R8 enabled write keeps mask clear", d, 32'h0000_0041);

    wr(3'd4, 32'hF);
    rd(3'd4, d); chk("R1 divide bits kept", d, 32'hB);

    // one-shot, ratio 1
    wr(3'd2, 7); w = cyc;
    push(w + 3, 8'h41);
    rd(3'd3, d); chk("R2 load on write", d, 7);
    wait_until(w + 1);
    rd(3'd3, d); chk("R3 step decrement", d, 4);
    wait_until(w + 10);
    rd(3'd3, d); chk("R5 one-shot stays zero", d, 0);
    wr(3'd3, 32'h55);
    rd(3'd3, d); chk("R10 cur read-only", d, 0);

    // periodic, ratio 2
    wr(3'd4, 32'h0);
    wr(3'd1, 32'h0002_0052);
    wr(3'd2, 7); w = cyc;
    push(w + 6, 8'h52); push(w + 10, 8'h52); push(w + 14, 8'h52);
    wait_until(w + 6);
    rd(3'd3, d); chk("R6 reload minus overshoot", d, 5);
    wait_until(w + 10);
    rd(3'd3, d); chk("R6 second reload", d, 6);
    wait_until(w + 16);
    wr(3'd2, 0);
    repeat (30) @(negedge clk);
    rd(3'd3, d); chk("R4 zero init stops", d, 0);

    // overshoot not smaller than initial count
    wr(3'd2, 2); w = cyc;
    push(w + 2, 8'h52); push(w + 4, 8'h52);
    wait_until(w + 2);
    rd(3'd3, d); chk("R6 partial reload", d, 1);
    wait_until(w + 4);
    rd(3'd3, d); chk("R6 clamp to zero", d, 0);
    wr(3'd2, 0);
    repeat (10) @(negedge clk);

    // masked expiry
    wr(3'd1, 32'h0001_0060);
    wr(3'd4, 32'hB);
    wr(3'd2, 3); w = cyc;
    wait_until(w + 5);
    rd(3'd3, d); chk("R7 masked expiry still counts", d, 0);

    // ratio 8
    wr(3'd1, 32'h0000_0063);
    wr(3'd4, 32'h2);
    wr(3'd2, 4); w = cyc;
    push(w + 16, 8'h63);
    wait_until(w + 7);
    rd(3'd3, d); chk("R2 no decrement before ratio", d, 4);
    wait_until(w + 8);
    rd(3'd3, d); chk("R1 ratio 8 decrement", d, 1);
    wait_until(w + 20);

    // ratio 64
    wr(3'd4, 32'h9);
    wr(3'd2, 1); w = cyc;
    push(w + 64, 8'h63);
    wait_until(w + 63);
    rd(3'd3, d); chk("R1 ratio 64 pending", d, 1);
    wait_until(w + 70);

    // bit 2 ignored -> ratio 2
    wr(3'd4, 32'h4);
    rd(3'd4, d); chk("R1 bit2 dropped", d, 0);
    wr(3'd2, 1); w = cyc;
    push(w + 2, 8'h63);
    wait_until(w + 8);

    // periodic with zero initial count
    wr(3'd1, 32'h0002_0070);
    wr(3'd2, 0);
    repeat (20) @(negedge clk);
    rd(3'd3, d); chk("R4 periodic zero init idle", d, 0);

    repeat (20) @(negedge clk);
    chk("R7 all expected requests seen", exp_cyc.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule